// File: doc/BRIEF.md
# Program-Check Trap and Privilege Gate

This block sits after the instruction decoder and is consulted once for every decoded instruction. From the operation class, a flag taken from the high bit of any special-register number in the instruction, an illegal-opcode flag, the current instruction address and the machine state word, it decides one of four outcomes. The instruction may proceed, and the address advances by one instruction. It may raise a privilege fault. It may raise an illegal-instruction fault. Or, for the attention operation, it may stop the machine.

On either fault the block does four things. It saves the faulting address into save/restore word 0. It saves a copy of the state word, with a cause bit set, into save/restore word 1. It redirects to the program-check vector. It rewrites the state word into supervisor, translation-off, interrupts-off form. All results are registered and change only on a cycle in which the valid strobe is high. A halt is sticky until reset.

Top module: `exc_trap_checker`

## Requirements
- R1: While reset (`rst_n` low) is applied, `next_pc` holds the `START_PC` parameter, and `srr0`, `srr1`, `state_out` and `halted` are all zero.
- R2: An accepted instruction that neither faults nor halts sets `next_pc` to `cur_pc + 4`, wrapping modulo 2^64. It copies `state_in` to `state_out` and leaves `srr0`/`srr1` unchanged.
- R3: The `op_class` codes are 0 ordinary, 1 attention, 2 read-state, 3 write-state, 4 write-state-wide, 5 return-from-interrupt, 6 read-special-register and 7 write-special-register. Codes 1 to 5 are always privileged. A privileged instruction faults when the problem-state bit (`state_in` bit 14) is 1, and executes normally when that bit is 0.
- R4: Codes 6 and 7 are privileged only when `spr_hi` is 1. With `spr_hi` at 0 they execute even in problem state.
- R5: A privilege fault sets `next_pc` to `TRAP_VEC` (default 0x700) and `srr0` to `cur_pc`. It sets `srr1` to `state_in` with bit 18 forced to 1.
- R6: An accepted instruction with `illegal` high that is not a privilege fault (and not a permitted attention) takes an illegal-instruction fault. That fault gives the same `next_pc` and `srr0` as R5, but `srr1` is `state_in` with bit 19 forced to 1. The privilege fault wins when both apply.
- R7: On either fault, `state_out` is `state_in` with bits 63 and 0 set to 1, and bits 15, 14, 5, 4 and 1 cleared.
- R8: A permitted attention (code 1 with bit 14 clear) sets `halted` and sets `next_pc` to `cur_pc`. It leaves `state_out`, `srr0` and `srr1` unchanged.
- R9: Once `halted` is 1, it stays 1 and no output changes for any input until reset.
- R10: In a cycle with `insn_valid` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | One-cycle strobe: an instruction is presented |
| op_class | input | 4 | Operation class code (see R3) |
| spr_hi | input | 1 | High bit of the special-register number field |
| illegal | input | 1 | Decoder found no valid opcode |
| cur_pc | input | 64 | Address of the presented instruction |
| state_in | input | 64 | Current machine state word |
| next_pc | output | 64 | Address of the next instruction |
| srr0 | output | 64 | Save/restore word 0 (faulting address) |
| srr1 | output | 64 | Save/restore word 1 (saved state plus cause bit) |
| state_out | output | 64 | Updated machine state word |
| halted | output | 1 | Sticky stop flag |

## Verification
Every result is registered exactly once, so each outcome of a strobe is visible one rising edge after the strobe. That covers the address, both save words, the state word and the halt flag. The bench drives inputs on the falling edge and holds the strobe for one cycle. It then samples on the following falling edge, which lies after that single register stage and before any later strobe can disturb the outputs. For the idle and halted cases, the bench leaves a full extra cycle before it samples, so that an unwanted change would have had time to appear.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN = 64;

  typedef enum logic [3:0] {
    OPC_PLAIN      = 4'd0,
    OPC_HALT       = 4'd1,
    OPC_RD_STATE   = 4'd2,
    OPC_WR_STATE   = 4'd3,
    OPC_WR_STATE_W = 4'd4,
    OPC_RET_INT    = 4'd5,
    OPC_RD_SPREG   = 4'd6,
    OPC_WR_SPREG   = 4'd7
  } op_class_e;

  // state word bit positions (bit 0 = least significant)
  localparam int ST_WIDE  = 63;
  localparam int ST_IRQ   = 15;
  localparam int ST_USER  = 14;
  localparam int ST_ITRAN = 5;
  localparam int ST_DTRAN = 4;
  localparam int ST_RECOV = 1;
  localparam int ST_LITTL = 0;

  // cause bits placed in the saved state copy
  localparam int WHY_ILL  = 19;
  localparam int WHY_PRIV = 18;

  function automatic logic [XLEN-1:0] seq_next(input logic [XLEN-1:0] pc,
                                               input logic [XLEN-1:0] step);
    return pc + step;
  endfunction

  function automatic logic [XLEN-1:0] trap_state(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[ST_WIDE]  = 1'b1;
    r[ST_IRQ]   = 1'b0;
    r[ST_USER]  = 1'b0;
    r[ST_ITRAN] = 1'b0;
    r[ST_DTRAN] = 1'b0;
    r[ST_RECOV] = 1'b0;
    r[ST_LITTL] = 1'b1;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] saved_state(input logic [XLEN-1:0] s,
                                                  input logic priv_cause);
    logic [XLEN-1:0] r;
    r = s;
    if (priv_cause) r[WHY_PRIV] = 1'b1;
    else            r[WHY_ILL]  = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/exc_priv_classify.sv
module exc_priv_classify
  import exc_pkg::*;
(
  input  logic [3:0] op_class,
  input  logic       spr_hi,
  output logic       is_priv
);

  localparam int NUM_FIXED = 5;
  localparam op_class_e FIXED_LIST [NUM_FIXED] = '{
    OPC_HALT, OPC_RD_STATE, OPC_WR_STATE, OPC_WR_STATE_W, OPC_RET_INT
  };

  logic [NUM_FIXED-1:0] fixed_hit;

  generate
    for (genvar i = 0; i < NUM_FIXED; i++) begin : g_fixed
      assign fixed_hit[i] = (op_class == FIXED_LIST[i]);
    end
  endgenerate

  logic spreg_move;
  assign spreg_move = (op_class == OPC_RD_SPREG) || (op_class == OPC_WR_SPREG);
  assign is_priv    = (|fixed_hit) || (spreg_move && spr_hi);

endmodule

// File: rtl/exc_trap_builder.sv
module exc_trap_builder
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] TRAP_VEC = 64'h700
)(
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] state_in,
  input  logic            priv_cause,
  output logic [XLEN-1:0] tgt_pc,
  output logic [XLEN-1:0] save0,
  output logic [XLEN-1:0] save1,
  output logic [XLEN-1:0] new_state
);

  assign tgt_pc    = TRAP_VEC;
  assign save0     = cur_pc;
  assign save1     = saved_state(state_in, priv_cause);
  assign new_state = trap_state(state_in);

endmodule

// File: rtl/exc_trap_checker.sv
module exc_trap_checker
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] START_PC   = 64'h100,
  parameter logic [XLEN-1:0] TRAP_VEC   = 64'h700,
  parameter int              INSN_BYTES = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_valid,
  input  logic [3:0]      op_class,
  input  logic            spr_hi,
  input  logic            illegal,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] state_in,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] srr0,
  output logic [XLEN-1:0] srr1,
  output logic [XLEN-1:0] state_out,
  output logic            halted
);

  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic is_priv;
  exc_priv_classify u_cls (
    .op_class (op_class),
    .spr_hi   (spr_hi),
    .is_priv  (is_priv)
  );

  // named events, in priority order
  logic accept, evt_priv_trap, evt_halt, evt_ill_trap, evt_advance, evt_trap;
  assign accept        = insn_valid && !halted;
  assign evt_priv_trap = accept && is_priv && state_in[ST_USER];
  assign evt_halt      = accept && !evt_priv_trap && (op_class == OPC_HALT);
  assign evt_ill_trap  = accept && !evt_priv_trap && !evt_halt && illegal;
  assign evt_advance   = accept && !evt_priv_trap && !evt_halt && !evt_ill_trap;
  assign evt_trap      = evt_priv_trap || evt_ill_trap;

  logic [XLEN-1:0] t_pc, t_s0, t_s1, t_st;
  exc_trap_builder #(.TRAP_VEC(TRAP_VEC)) u_bld (
    .cur_pc     (cur_pc),
    .state_in   (state_in),
    .priv_cause (evt_priv_trap),
    .tgt_pc     (t_pc),
    .save0      (t_s0),
    .save1      (t_s1),
    .new_state  (t_st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc   <= START_PC;
      srr0      <= '0;
      srr1      <= '0;
      state_out <= '0;
      halted    <= 1'b0;
    end else if (evt_trap) begin
      next_pc   <= t_pc;
      srr0      <= t_s0;
      srr1      <= t_s1;
      state_out <= t_st;
    end else if (evt_halt) begin
      next_pc   <= cur_pc;
      halted    <= 1'b1;
    end else if (evt_advance) begin
      next_pc   <= seq_next(cur_pc, STEP);
      state_out <= state_in;
    end
  end

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_advance |=> (next_pc == $past(cur_pc) + STEP) && (state_out == $past(state_in))
                    && $stable(srr0) && $stable(srr1));

  // R5
  priv_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_priv_trap |=> (next_pc == TRAP_VEC) && (srr0 == $past(cur_pc)) && srr1[WHY_PRIV]);

  // R6
  ill_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ill_trap |=> (next_pc == TRAP_VEC) &&
                     (srr1 == ($past(state_in) | (64'd1 << WHY_ILL))));

  // R7
  trap_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_trap |=> state_out[ST_WIDE] && state_out[ST_LITTL] && !state_out[ST_USER]
                 && !state_out[ST_IRQ] && !state_out[ST_ITRAN] && !state_out[ST_DTRAN]
                 && !state_out[ST_RECOV]);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(next_pc) && $stable(state_out) && $stable(srr1));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !insn_valid |=> $stable(next_pc) && $stable(srr0) && $stable(srr1) && $stable(halted));

endmodule

// File: tb/tb_exc_trap_checker.sv
`timescale 1ns/1ps
module tb_exc_trap_checker;

  localparam logic [63:0] START = 64'h3000;
  localparam logic [63:0] VECT  = 64'h700;
  localparam int NV = 13;
  // {op[3:0], spr_hi, illegal, user_bit, kind[1:0]}  kind: 0 advance, 1 priv, 2 illegal
  localparam logic [8:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 1'b1, 2'd0},   // R2 plain in user state
    {4'd2, 1'b0, 1'b0, 1'b0, 2'd0},   // R3 read-state, supervisor
    {4'd2, 1'b0, 1'b0, 1'b1, 2'd1},   // R3
    {4'd3, 1'b0, 1'b0, 1'b1, 2'd1},   // R3
    {4'd4, 1'b0, 1'b0, 1'b1, 2'd1},   // R3
    {4'd5, 1'b0, 1'b0, 1'b1, 2'd1},   // R3
    {4'd1, 1'b0, 1'b0, 1'b1, 2'd1},   // R3 attention in user state
    {4'd6, 1'b0, 1'b0, 1'b1, 2'd0},   // R4
    {4'd7, 1'b1, 1'b0, 1'b1, 2'd1},   // R4
    {4'd6, 1'b1, 1'b0, 1'b0, 2'd0},   // R4
    {4'd0, 1'b0, 1'b1, 1'b0, 2'd2},   // R6
    {4'd3, 1'b0, 1'b1, 1'b1, 2'd1},   // R6 priority
    {4'd0, 1'b0, 1'b1, 1'b1, 2'd2}    // R6
  };

  logic clk = 0, rst_n = 0, insn_valid = 0, spr_hi = 0, illegal = 0;
  logic [3:0]  op_class = 0;
  logic [63:0] cur_pc = 0, state_in = 0;
  logic [63:0] next_pc, srr0, srr1, state_out;
  logic        halted;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  exc_trap_checker #(.START_PC(START)) dut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .op_class(op_class),
    .spr_hi(spr_hi), .illegal(illegal), .cur_pc(cur_pc), .state_in(state_in),
    .next_pc(next_pc), .srr0(srr0), .srr1(srr1), .state_out(state_out),
    .halted(halted));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic sh, input logic il,
                       input logic [63:0] pc, input logic [63:0] st);
    @(negedge clk);
    op_class = op; spr_hi = sh; illegal = il; cur_pc = pc; state_in = st;
    insn_valid = 1;
    @(negedge clk);
    insn_valid = 0;
  endtask

  function automatic logic [63:0] fault_state(input logic [63:0] s);
    logic [63:0] r = s;
    r = r | 64'h8000_0000_0000_0001;
    r = r & ~(64'h1 << 15) & ~(64'h1 << 14) & ~(64'h1 << 5) & ~(64'h1 << 4) & ~(64'h1 << 1);
    return r;
  endfunction

  logic [63:0] e_s0, e_s1, e_st, e_pc;

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %h expected %h", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(next_pc == START, "R1 next_pc", next_pc, START);
    chk(srr0 == 0 && srr1 == 0, "R1 save words", srr0 | srr1, 64'h0);
    chk(state_out == 0, "R1 state_out", state_out, 64'h0);
    chk(halted == 0, "R1 halted", {63'h0, halted}, 64'h0);
    rst_n = 1;
    e_s0 = 0; e_s1 = 0;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] pc, st;
      logic [1:0] kind;
      pc = 64'h1000 + 64'(i) * 64'h40;
      st = 64'h5A3C_0F0F_1234_803F ^ 64'(i << 8);
      st[14] = VEC[i][2];
      kind = VEC[i][1:0];
      issue(VEC[i][8:5], VEC[i][4], VEC[i][3], pc, st);
      if (kind == 2'd0) begin
        e_pc = pc + 64'd4; e_st = st;
      end else begin
        e_pc = VECT; e_st = fault_state(st); e_s0 = pc;
        e_s1 = st | (64'h1 << ((kind == 2'd1) ? 18 : 19));
      end
      chk(next_pc == e_pc, (kind == 0) ? "R2/R3/R4 next_pc" : "R5/R6 next_pc", next_pc, e_pc);
      chk(srr0 == e_s0, "R5 srr0", srr0, e_s0);
      chk(srr1 == e_s1, (kind == 2) ? "R6 srr1" : "R5 srr1", srr1, e_s1);
      chk(state_out == e_st, (kind == 0) ? "R2 state_out" : "R7 state_out", state_out, e_st);
      chk(halted == 0, "R3 halted", {63'h0, halted}, 64'h0);
    end

    // R2 wrap of the address
    issue(4'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0);
    chk(next_pc == 64'h0, "R2 wrap", next_pc, 64'h0);

    // R10 idle cycles leave everything alone
    e_pc = next_pc; e_s1 = srr1;
    op_class = 4'd0; illegal = 1; state_in = 64'h4000;
    repeat (2) @(negedge clk);
    chk(next_pc == e_pc && srr1 == e_s1, "R10 idle", next_pc, e_pc);
    illegal = 0;

    // R8 permitted attention
    e_s0 = srr0; e_s1 = srr1; e_st = state_out;
    issue(4'd1, 0, 0, 64'h2000, 64'h0);
    chk(halted == 1, "R8 halted", {63'h0, halted}, 64'h1);
    chk(next_pc == 64'h2000, "R8 next_pc", next_pc, 64'h2000);
    chk(state_out == e_st && srr0 == e_s0 && srr1 == e_s1, "R8 unchanged", state_out, e_st);

    // R9 halted ignores an illegal and a privileged fault
    issue(4'd0, 0, 1, 64'h2004, 64'h0);
    issue(4'd2, 0, 0, 64'h2008, 64'h4000);
    @(negedge clk);
    chk(next_pc == 64'h2000, "R9 next_pc", next_pc, 64'h2000);
    chk(srr0 == e_s0 && srr1 == e_s1, "R9 save words", srr1, e_s1);
    chk(halted == 1, "R9 sticky", {63'h0, halted}, 64'h1);

    // R1 / R9 reset clears the halt
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(halted == 0 && next_pc == START, "R1 after reset", next_pc, START);
    rst_n = 1;
    issue(4'd0, 0, 0, 64'h500, 64'h0);
    chk(next_pc == 64'h504, "R9 runs after reset", next_pc, 64'h504);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule